// File: doc/BRIEF.md
# Monitor Sync and Colour Burst Shaper

This block turns the raw horizontal and vertical sync pulses of a CRT timing controller into the three timing signals a composite monitor stage needs: a shaped horizontal sync, a colour burst gate and a shaped vertical sync. It runs on the low-resolution pixel clock (LCLK), which is synchronous with the controller's character clock. The controller's horizontal pulse is programmable from 1 to 16 character ticks. A tick is one LCLK in 40-column modes and half an LCLK in 80-column modes, so the same setting gives half the pulse length at high resolution.

The shaped horizontal sync and the burst gate are fixed-offset windows counted from the rising edge of the controller's pulse. Both are gated by that pulse, so a short pulse cuts them short or removes them. This is why a 10-tick pulse in 80-column text gives a shortened sync and no colour burst. The shaped vertical sync lasts three scanlines and always starts together with a shaped horizontal sync. A field therefore never starts in the middle of a line.

Top module: `csync_burst_gen`

## Requirements
- R1: A synchronous active-high reset drives all three outputs low and clears the line phase and any pending vertical request. A vertical edge seen before the reset does not produce a vertical sync after it.
- R2: Call e0 the first clock edge that samples the controller hsync high after a low sample. The shaped hsync rises after edge e(HS_DELAY), where HS_DELAY defaults to 2.
- R3: The shaped hsync is high after edge ek only for k from HS_DELAY to HS_DELAY+3, and only if edge ek samples the controller hsync high. It is therefore at most 4 LCLK long and ends early when the controller pulse ends.
- R4: The burst gate is high after edge ek only for k from HS_DELAY+5 to HS_DELAY+6, and only if edge ek samples the controller hsync high. With the default this is edges 7 and 8.
- R5: A controller pulse of W LCLK with W no greater than HS_DELAY+5 gives no burst. With the default setting, a 10-tick pulse in 80-column mode (5 LCLK) gives a 3-LCLK shaped hsync and no burst, and a 16-tick pulse (8 LCLK) gives a 1-LCLK burst.
- R6: The shaped vsync rises in the same cycle as the shaped hsync that follows the vertical request. It stays high for 3 lines and falls at the fourth shaped-hsync start.
- R7: A rising edge of the controller vsync is held as a request even if the controller vsync falls again before the next shaped-hsync start.
- R8: A new rising edge of the controller hsync restarts the window timing from e0, even while earlier windows are still running.
- R9: With HS_DELAY set to 1, the burst moves to edges 6 and 7, so a 16-tick pulse in 80-column mode (8 LCLK) gives the full 2-LCLK burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCLK, the low-resolution pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| crtc_hs_i | input | 1 | Raw horizontal sync from the timing controller |
| crtc_vs_i | input | 1 | Raw vertical sync from the timing controller |
| mon_hs_o | output | 1 | Shaped horizontal sync to the monitor |
| burst_o | output | 1 | Colour burst gate |
| mon_vs_o | output | 1 | Shaped vertical sync, aligned to a shaped hsync start |

## Verification
The properties assume that both controller sync inputs are already synchronous to LCLK and change only between rising edges. They also assume the offsets keep the burst window after the end of the shaped hsync, which holds for the defaults and for HS_DELAY of 1. The stimulus drives every input on the falling edge, one sample per LCLK. It starts each pulse pattern after enough low cycles that the line phase has saturated. It holds the controller hsync low while reset is applied, so no rising edge falls inside the reset window.

// File: rtl/csync_pkg.sv
package csync_pkg;

  // True when phase ph lies in the window [start, start+len).
  function automatic logic in_span(input int ph, input int start, input int len);
    return (ph >= start) && (ph < start + len);
  endfunction

  // Largest of two integers, used to size the phase counter.
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/csync_edge_det.sv
module csync_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/csync_line_timer.sv
module csync_line_timer #(
  parameter int HS_DELAY  = 2,
  parameter int HS_LEN    = 4,
  parameter int BURST_GAP = 5,
  parameter int BURST_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_i,
  input  logic rise_i,
  output logic hs_o,
  output logic burst_o,
  output logic hs_start_o
);
  import csync_pkg::*;

  localparam int BURST_AT = HS_DELAY + BURST_GAP;
  localparam int PH_SAT   = max2(HS_DELAY + HS_LEN, BURST_AT + BURST_LEN);
  localparam int PH_W     = $clog2(PH_SAT + 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_n;

  // Phase restarts on each controller edge and parks at PH_SAT.
  always_comb begin
    if (rise_i)                      ph_n = '0;
    else if (ph_q == PH_W'(PH_SAT))  ph_n = ph_q;
    else                             ph_n = ph_q + PH_W'(1);
  end

  assign hs_start_o = hs_i & (ph_n == PH_W'(HS_DELAY));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_W'(PH_SAT);
      hs_o    <= 1'b0;
      burst_o <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      hs_o    <= hs_i & in_span(int'(ph_n), HS_DELAY, HS_LEN);
      burst_o <= hs_i & in_span(int'(ph_n), BURST_AT, BURST_LEN);
    end
  end
endmodule

// File: rtl/csync_field_seq.sv
module csync_field_seq #(
  parameter int VS_LINES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic vs_rise_i,
  input  logic hs_start_i,
  output logic vs_o
);
  localparam int LINE_W = $clog2(VS_LINES + 1);

  logic              pend_q;
  logic              pend_n;
  logic [LINE_W-1:0] left_q;

  assign pend_n = pend_q | vs_rise_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      left_q <= '0;
      vs_o   <= 1'b0;
    end else if (hs_start_i && left_q != '0) begin
      left_q <= left_q - LINE_W'(1);
      vs_o   <= (left_q != LINE_W'(1));
      pend_q <= pend_n;
    end else if (hs_start_i && pend_n) begin
      left_q <= LINE_W'(VS_LINES);
      vs_o   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/csync_burst_gen.sv
module csync_burst_gen #(
  parameter int HS_DELAY  = 2,
  parameter int HS_LEN    = 4,
  parameter int BURST_GAP = 5,
  parameter int BURST_LEN = 2,
  parameter int VS_LINES  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic crtc_hs_i,
  input  logic crtc_vs_i,
  output logic mon_hs_o,
  output logic burst_o,
  output logic mon_vs_o
);
  logic hs_rise;
  logic vs_rise;
  logic hs_start;

  csync_edge_det hs_edge_i (.clk(clk), .rst(rst), .d_i(crtc_hs_i), .rise_o(hs_rise));
  csync_edge_det vs_edge_i (.clk(clk), .rst(rst), .d_i(crtc_vs_i), .rise_o(vs_rise));

  csync_line_timer #(
    .HS_DELAY(HS_DELAY), .HS_LEN(HS_LEN),
    .BURST_GAP(BURST_GAP), .BURST_LEN(BURST_LEN)
  ) line_i (
    .clk(clk), .rst(rst), .hs_i(crtc_hs_i), .rise_i(hs_rise),
    .hs_o(mon_hs_o), .burst_o(burst_o), .hs_start_o(hs_start)
  );

  csync_field_seq #(.VS_LINES(VS_LINES)) field_i (
    .clk(clk), .rst(rst), .vs_rise_i(vs_rise),
    .hs_start_i(hs_start), .vs_o(mon_vs_o)
  );
endmodule

// File: rtl/csync_burst_gen_chk.sv
module csync_burst_gen_chk #(
  parameter int HS_LEN    = 4,
  parameter int BURST_LEN = 2,
  parameter int VS_LINES  = 3
) (
  input logic clk,
  input logic rst,
  input logic crtc_hs_i,
  input logic mon_hs_o,
  input logic burst_o,
  input logic mon_vs_o,
  input logic hs_start
);
  localparam int RUN_W = $clog2(HS_LEN + BURST_LEN + VS_LINES + 2);

  logic [RUN_W-1:0] hs_run, bu_run, vs_lines;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_run <= '0; bu_run <= '0; vs_lines <= '0;
    end else begin
      hs_run   <= mon_hs_o ? ((hs_run == '1) ? hs_run : hs_run + RUN_W'(1)) : '0;
      bu_run   <= burst_o  ? ((bu_run == '1) ? bu_run : bu_run + RUN_W'(1)) : '0;
      vs_lines <= !mon_vs_o ? '0 :
                  ($rose(mon_hs_o) && vs_lines != '1) ? vs_lines + RUN_W'(1) : vs_lines;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!mon_hs_o && !burst_o && !mon_vs_o)); // R1
  AST_HS_GATED: assert property (@(posedge clk) disable iff (rst)
    mon_hs_o |-> $past(crtc_hs_i)); // R3
  AST_HS_MAXLEN: assert property (@(posedge clk) disable iff (rst)
    mon_hs_o |-> (hs_run < RUN_W'(HS_LEN))); // R3
  AST_BURST_GATED: assert property (@(posedge clk) disable iff (rst)
    burst_o |-> $past(crtc_hs_i)); // R4
  AST_BURST_MAXLEN: assert property (@(posedge clk) disable iff (rst)
    burst_o |-> (bu_run < RUN_W'(BURST_LEN))); // R4
  AST_BURST_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_o) |-> !mon_hs_o); // R4
  AST_VS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_vs_o) |-> $rose(mon_hs_o)); // R6
  AST_VS_START_EVENT: assert property (@(posedge clk) disable iff (rst)
    (hs_start && !mon_vs_o) |=> (mon_hs_o)); // R2
  AST_VS_MAXLINES: assert property (@(posedge clk) disable iff (rst)
    (mon_vs_o && $rose(mon_hs_o)) |-> (vs_lines < RUN_W'(VS_LINES))); // R6
endmodule

bind csync_burst_gen csync_burst_gen_chk #(
  .HS_LEN(HS_LEN), .BURST_LEN(BURST_LEN), .VS_LINES(VS_LINES)
) chk_i (
  .clk(clk), .rst(rst), .crtc_hs_i(crtc_hs_i), .mon_hs_o(mon_hs_o),
  .burst_o(burst_o), .mon_vs_o(mon_vs_o), .hs_start(hs_start)
);

// File: tb/csync_burst_gen_tb_top.sv
module csync_burst_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crtc_hs = 1'b0;
  logic crtc_vs = 1'b0;
  logic hs2, bu2, vs2, hs1, bu1, vs1;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  csync_burst_gen dut_i (
    .clk(clk), .rst(rst), .crtc_hs_i(crtc_hs), .crtc_vs_i(crtc_vs),
    .mon_hs_o(hs2), .burst_o(bu2), .mon_vs_o(vs2)
  );

  csync_burst_gen #(.HS_DELAY(1)) dut1_i (
    .clk(clk), .rst(rst), .crtc_hs_i(crtc_hs), .crtc_vs_i(crtc_vs),
    .mon_hs_o(hs1), .burst_o(bu1), .mon_vs_o(vs1)
  );

  // Bit k of a pattern is the controller hsync sampled at edge k; bit k of
  // an expectation is the output level after edge k.
  localparam int NV = 10;
  localparam logic [31:0] PAT [NV] = '{32'h3FF, 32'h1F, 32'hFF, 32'h1, 32'h7,
                                       32'hFFFF, 32'h3, 32'h7F, 32'h7FEF, 32'h3F};
  localparam logic [31:0] EH2 [NV] = '{32'h3C, 32'h1C, 32'h3C, 32'h0, 32'h4,
                                       32'h3C, 32'h0, 32'h3C, 32'h78C, 32'h3C};
  localparam logic [31:0] EB2 [NV] = '{32'h180, 32'h0, 32'h80, 32'h0, 32'h0,
                                       32'h180, 32'h0, 32'h0, 32'h3000, 32'h0};
  localparam logic [31:0] EH1 [NV] = '{32'h1E, 32'h1E, 32'h1E, 32'h0, 32'h6,
                                       32'h1E, 32'h2, 32'h1E, 32'h3CE, 32'h1E};
  localparam logic [31:0] EB1 [NV] = '{32'hC0, 32'h0, 32'hC0, 32'h0, 32'h0,
                                       32'hC0, 32'h0, 32'h40, 32'h1800, 32'h0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] oh2, ob2, oh1, ob1;
    int vs_first, vs_count, vs_hs_rose;
    logic prev_hs;

    idle(3);
    check("R1 reset outputs", {29'd0, hs2, bu2, vs2}, 32'd0);
    rst = 1'b0;
    idle(12);

    // Vector walk: pulse widths in LCLK for 40- and 80-column settings.
    for (int v = 0; v < NV; v++) begin
      oh2 = '0; ob2 = '0; oh1 = '0; ob1 = '0;
      for (int k = 0; k < 32; k++) begin
        crtc_hs = PAT[v][k];
        @(negedge clk);
        oh2[k] = hs2; ob2[k] = bu2; oh1[k] = hs1; ob1[k] = bu1;
      end
      check(v == 8 ? "R8 retrigger hsync" : "R2 R3 hsync window", oh2, EH2[v]);
      check(v == 8 ? "R8 retrigger burst" : "R4 R5 burst window", ob2, EB2[v]);
      check("R9 hsync with delay 1", oh1, EH1[v]);
      check("R9 burst with delay 1", ob1, EB1[v]);
    end

    // Vertical: one-cycle vsync pulse mid-line, lines of 20 LCLK, 10 high.
    vs_first = -1; vs_count = 0; vs_hs_rose = 0; prev_hs = 1'b0;
    for (int c = 0; c < 140; c++) begin
      crtc_hs = ((c % 20) < 10);
      crtc_vs = (c == 25);
      @(negedge clk);
      if (vs2) begin
        vs_count++;
        if (vs_first < 0) begin
          vs_first = c;
          vs_hs_rose = (hs2 && !prev_hs) ? 1 : 0;
        end
      end
      prev_hs = hs2;
    end
    check("R7 vsync request held to next line", 32'(vs_first), 32'd42);
    check("R6 vsync aligned to hsync rise", 32'(vs_hs_rose), 32'd1);
    check("R6 vsync lasts 3 lines", 32'(vs_count), 32'd60);
    crtc_hs = 1'b0;
    idle(12);

    // Reset in the middle of a pulse forces outputs low.
    for (int k = 0; k < 3; k++) begin crtc_hs = 1'b1; @(negedge clk); end
    check("R2 hsync up before reset", {31'd0, hs2}, 32'd1);
    rst = 1'b1; crtc_hs = 1'b0;
    @(negedge clk);
    check("R1 reset mid-pulse", {29'd0, hs2, bu2, vs2}, 32'd0);
    rst = 1'b0;
    idle(12);

    // A vsync edge before reset must not survive it.
    crtc_vs = 1'b1; @(negedge clk); crtc_vs = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    vs_count = 0;
    for (int c = 0; c < 60; c++) begin
      crtc_hs = ((c % 20) < 10);
      @(negedge clk);
      if (vs2) vs_count++;
    end
    check("R1 pending vsync cleared", 32'(vs_count), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule